// File: doc/BRIEF.md
# Dual-Section Registered Bus Transceiver

This block links an A-side bus and a B-side bus, 16 bits each, as two independent 8-bit sections. Each section has its own controls. A section can drive the B bus from the A bus, drive the A bus from the B bus, do both, or isolate the two buses. Each section holds one capture register per direction. Each driven bus carries either the live value of the opposite bus or the value held in the matching capture register.

The bidirectional pins are split into an input vector, an output vector and a per-bit output-enable vector for each bus. The capture clocks are treated as plain inputs. A rising edge on a capture clock is detected in the system clock domain, and on that event the register takes the current bus value. Capture works whatever the enables and selects are.

Data outputs, output enables and the error flag are registered. A select change therefore moves a whole byte from one source to the other in a single clock edge.

Top module: `dual_bus_xcvr`

## Requirements
- R1: The B bus of section s is driven (all 8 `b_oe_o` bits = 1) one cycle after `en_ab_i[s]`=1, unless the error state of R8 applies. Otherwise all 8 bits are 0.
- R2: The A bus of section s is driven (all 8 `a_oe_o` bits = 1) one cycle after the active-low `en_ba_n_i[s]`=0, unless the error state of R8 applies. Otherwise all 8 bits are 0.
- R3: While `rst_ni`=0, all output enables, data outputs and `conflict_o` are 0, and all four capture registers are cleared to 0x00. With `en_ab_i`=0 and `en_ba_n_i`=1 a section drives neither bus.
- R4: With a select at 0, the driven bus shows the live value of the opposite bus input, delayed by one cycle.
- R5: With a select at 1, the driven bus shows the capture register of the opposite side: `sel_ab_i` shows register A on the B bus, and `sel_ba_i` shows register B on the A bus.
- R6: A rising edge on `cap_a_i[s]` (or `cap_b_i[s]`) loads the A (or B) bus byte into that section's register 2 cycles after the edge is sampled. This happens regardless of the enables and selects. A level held high loads nothing further.
- R7: With both directions enabled and both selects at 1, stored A data drives the B bus and stored B data drives the A bus at the same time.
- R8: With both directions enabled and both selects at 0, `conflict_o[s]` is 1 on the next cycle and neither bus of that section is driven.
- R9: When a select toggles, each output byte equals either the full live value or the full stored value, never a mix of the two.
- R10: Controls and captures of one section do not affect the other section's outputs, enables or error flag.
- R11: A capture edge on a bus that the section itself is driving in real time stores the driving value. One transfer can therefore fill both registers with the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 16 | A bus value seen at the pins |
| b_i | input | 16 | B bus value seen at the pins |
| en_ab_i | input | 2 | Per-section A-to-B drive enable, active high |
| en_ba_n_i | input | 2 | Per-section B-to-A drive enable, active low |
| sel_ab_i | input | 2 | Per-section B bus source: 0 live A, 1 register A |
| sel_ba_i | input | 2 | Per-section A bus source: 0 live B, 1 register B |
| cap_a_i | input | 2 | Per-section A capture clock |
| cap_b_i | input | 2 | Per-section B capture clock |
| a_o | output | 16 | Data driven onto the A bus |
| a_oe_o | output | 16 | Per-bit A bus drive enable |
| b_o | output | 16 | Data driven onto the B bus |
| b_oe_o | output | 16 | Per-bit B bus drive enable |
| conflict_o | output | 2 | Per-section flag for the unspecified live/live state |

## Verification
Live transfer is tried with several distinct byte values in each direction. This shows that the output follows the opposite bus, not a constant. Stored transfer uses register contents that differ from the current bus values, so a live path and a stored path cannot be mistaken for each other. This also holds while both directions drive at once. Rapid select toggling between complementary live and stored bytes exposes any bitwise mixing. A held capture level and a capture on a bus the block itself drives separate true edge detection from level loading, and show that the driven data rather than the external data is stored.

// File: rtl/dual_xcvr_pkg.sv
package dual_xcvr_pkg;
  typedef struct packed {
    logic en_ab;
    logic en_ba_n;
    logic sel_ab;
    logic sel_ba;
  } sect_ctrl_t;
endpackage

// File: rtl/xcvr_rise_detect.sv
module xcvr_rise_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], lvl_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import dual_xcvr_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sect_ctrl_t   ctrl_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o,
  output logic         conflict_o
);
  logic         rise_a, rise_b;
  logic [W-1:0] reg_a_q, reg_b_q;
  logic         conflict_d, drive_b, drive_a;
  logic [W-1:0] b_src, a_src;

  xcvr_rise_detect #(.SYNC_STAGES(SYNC_STAGES)) u_rise_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(cap_a_i), .rise_o(rise_a));
  xcvr_rise_detect #(.SYNC_STAGES(SYNC_STAGES)) u_rise_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(cap_b_i), .rise_o(rise_b));

  // capture is independent of enables and selects
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_q <= '0;
      reg_b_q <= '0;
    end else begin
      if (rise_a) reg_a_q <= a_i;
      if (rise_b) reg_b_q <= b_i;
    end
  end

  always_comb begin
    conflict_d = ctrl_i.en_ab & ~ctrl_i.en_ba_n & ~ctrl_i.sel_ab & ~ctrl_i.sel_ba;
    drive_b    = ctrl_i.en_ab & ~conflict_d;
    drive_a    = ~ctrl_i.en_ba_n & ~conflict_d;
    b_src      = ctrl_i.sel_ab ? reg_a_q : a_i;
    a_src      = ctrl_i.sel_ba ? reg_b_q : b_i;
  end

  // registered outputs: whole byte switches source on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_o        <= '0;
      b_oe_o     <= '0;
      a_o        <= '0;
      a_oe_o     <= '0;
      conflict_o <= 1'b0;
    end else begin
      b_o        <= drive_b ? b_src : '0;
      b_oe_o     <= {W{drive_b}};
      a_o        <= drive_a ? a_src : '0;
      a_oe_o     <= {W{drive_a}};
      conflict_o <= conflict_d;
    end
  end

  assert_b_oe_needs_enable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|b_oe_o) |-> $past(ctrl_i.en_ab));
  assert_a_oe_needs_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|a_oe_o) |-> !$past(ctrl_i.en_ba_n));
  assert_stored_to_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.en_ab && ctrl_i.sel_ab) |=> (b_o == $past(reg_a_q)));
  assert_stored_to_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en_ba_n && ctrl_i.sel_ba) |=> (a_o == $past(reg_b_q)));
  assert_conflict_isolates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.en_ab && !ctrl_i.en_ba_n && !ctrl_i.sel_ab && !ctrl_i.sel_ba)
      |=> (conflict_o && b_oe_o == '0 && a_oe_o == '0));
  assert_hold_without_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_a && !rise_b) |=> ($stable(reg_a_q) && $stable(reg_b_q)));
  assert_uniform_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o == '0 || &b_oe_o) && (a_oe_o == '0 || &a_oe_o));
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import dual_xcvr_pkg::*;
#(
  parameter int unsigned N_SECT      = 2,
  parameter int unsigned SECT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BUS_W      = N_SECT * SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  a_i,
  input  logic [BUS_W-1:0]  b_i,
  input  logic [N_SECT-1:0] en_ab_i,
  input  logic [N_SECT-1:0] en_ba_n_i,
  input  logic [N_SECT-1:0] sel_ab_i,
  input  logic [N_SECT-1:0] sel_ba_i,
  input  logic [N_SECT-1:0] cap_a_i,
  input  logic [N_SECT-1:0] cap_b_i,
  output logic [BUS_W-1:0]  a_o,
  output logic [BUS_W-1:0]  a_oe_o,
  output logic [BUS_W-1:0]  b_o,
  output logic [BUS_W-1:0]  b_oe_o,
  output logic [N_SECT-1:0] conflict_o
);
  for (genvar s = 0; s < N_SECT; s++) begin : g_sect
    sect_ctrl_t ctrl;
    assign ctrl = '{en_ab: en_ab_i[s], en_ba_n: en_ba_n_i[s],
                    sel_ab: sel_ab_i[s], sel_ba: sel_ba_i[s]};

    xcvr_section #(.W(SECT_W), .SYNC_STAGES(SYNC_STAGES)) u_sect (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_i     (ctrl),
      .a_i        (a_i[s*SECT_W +: SECT_W]),
      .b_i        (b_i[s*SECT_W +: SECT_W]),
      .cap_a_i    (cap_a_i[s]),
      .cap_b_i    (cap_b_i[s]),
      .a_o        (a_o[s*SECT_W +: SECT_W]),
      .a_oe_o     (a_oe_o[s*SECT_W +: SECT_W]),
      .b_o        (b_o[s*SECT_W +: SECT_W]),
      .b_oe_o     (b_oe_o[s*SECT_W +: SECT_W]),
      .conflict_o (conflict_o[s])
    );
  end

  assert_idle_in_reset_R3: assert property (@(posedge clk_i)
    !rst_ni |-> (a_oe_o == '0 && b_oe_o == '0 && conflict_o == '0));
endmodule

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_ext = '0, b_ext = '0;
  logic [15:0] a_bus, b_bus;
  logic [1:0]  en_ab = '0, en_ba_n = '1, sel_ab = '0, sel_ba = '0, cap_a = '0, cap_b = '0;
  logic [15:0] a_o, a_oe, b_o, b_oe;
  logic [1:0]  conflict;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;  // 125 MHz

  // resolved bus seen at the pins
  assign a_bus = (a_oe & a_o) | (~a_oe & a_ext);
  assign b_bus = (b_oe & b_o) | (~b_oe & b_ext);

  dual_bus_xcvr uut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_bus), .b_i(b_bus),
    .en_ab_i(en_ab), .en_ba_n_i(en_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .cap_a_i(cap_a), .cap_b_i(cap_b),
    .a_o(a_o), .a_oe_o(a_oe), .b_o(b_o), .b_oe_o(b_oe), .conflict_o(conflict));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic setc(int s, logic eab, logic ebn, logic sab, logic sba);
    en_ab[s] = eab; en_ba_n[s] = ebn; sel_ab[s] = sab; sel_ba[s] = sba;
  endtask

  task automatic pulse_a(int s);
    cap_a[s] = 1'b1; step(4); cap_a[s] = 1'b0; step(2);
  endtask

  task automatic pulse_b(int s);
    cap_b[s] = 1'b1; step(4); cap_b[s] = 1'b0; step(2);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R3 oe in reset", a_oe | b_oe, 16'h0);
    chk("R3 data in reset", a_o | b_o, 16'h0);
    step(2); rst_ni = 1'b1; step(2);
    chk("R3 isolation a_oe", a_oe, 16'h0);
    chk("R3 isolation b_oe", b_oe, 16'h0);
    setc(0, 1, 1, 1, 0); step(2);
    chk("R3 reg A cleared", {8'h0, b_o[7:0]}, 16'h0);
    setc(0, 0, 0, 0, 1); step(2);
    chk("R3 reg B cleared", {8'h0, a_o[7:0]}, 16'h0);
    setc(0, 0, 1, 0, 0); step(2);
  endtask

  task automatic t_realtime;
    setc(0, 1, 1, 0, 0); a_ext[7:0] = 8'h5A; step(2);
    chk("R4 live A->B 5A", {8'h0, b_o[7:0]}, 16'h005A);
    chk("R1 b_oe on", {8'h0, b_oe[7:0]}, 16'h00FF);
    chk("R2 a_oe off", {8'h0, a_oe[7:0]}, 16'h0);
    a_ext[7:0] = 8'hC3; step(1);
    chk("R4 live A->B C3", {8'h0, b_o[7:0]}, 16'h00C3);
    setc(0, 0, 0, 0, 0); b_ext[7:0] = 8'h96; step(2);
    chk("R4 live B->A 96", {8'h0, a_o[7:0]}, 16'h0096);
    chk("R2 a_oe on", {8'h0, a_oe[7:0]}, 16'h00FF);
    chk("R1 b_oe off", {8'h0, b_oe[7:0]}, 16'h0);
    setc(0, 0, 1, 0, 0); step(2);
  endtask

  task automatic t_capture;
    a_ext[7:0] = 8'h3C; pulse_a(0);
    a_ext[7:0] = 8'h00;
    setc(0, 1, 1, 1, 0); step(2);
    chk("R6 captured in isolation", {8'h0, b_o[7:0]}, 16'h003C);
    chk("R5 stored A->B", {8'h0, b_oe[7:0]}, 16'h00FF);
    setc(0, 0, 1, 0, 0); a_ext[7:0] = 8'h81;
    cap_a[0] = 1'b1; step(4);
    a_ext[7:0] = 8'h18; step(4); cap_a[0] = 1'b0; step(2);
    setc(0, 1, 1, 1, 0); step(2);
    chk("R6 held level no reload", {8'h0, b_o[7:0]}, 16'h0081);
    setc(0, 0, 1, 0, 0); step(2);
  endtask

  task automatic t_both_stored;
    a_ext[7:0] = 8'h11; pulse_a(0);
    b_ext[7:0] = 8'h22; pulse_b(0);
    a_ext[7:0] = 8'hEE; b_ext[7:0] = 8'hDD;
    setc(0, 1, 0, 1, 1); step(2);
    chk("R7 stored A on B", {8'h0, b_o[7:0]}, 16'h0011);
    chk("R7 stored B on A", {8'h0, a_o[7:0]}, 16'h0022);
    chk("R7 no conflict", {14'h0, conflict}, 16'h0);
    setc(0, 0, 1, 0, 0); step(2);
  endtask

  task automatic t_conflict;
    setc(0, 1, 0, 0, 0); step(1);
    chk("R8 flag", {14'h0, conflict}, 16'h0001);
    chk("R8 no drive", {a_oe[7:0], b_oe[7:0]}, 16'h0);
    setc(0, 0, 1, 0, 0); step(1);
    chk("R8 flag clears", {14'h0, conflict}, 16'h0);
  endtask

  task automatic t_glitch;
    a_ext[7:0] = 8'h0F; pulse_a(0);
    a_ext[7:0] = 8'hF0;
    setc(0, 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) begin
      sel_ab[0] = i[0];
      step(1);
      chk("R9 whole byte", {8'h0, b_o[7:0]}, i[0] ? 16'h000F : 16'h00F0);
    end
    setc(0, 0, 1, 0, 0); step(2);
  endtask

  task automatic t_driven_capture;
    b_ext[7:0] = 8'h77; a_ext[7:0] = 8'h00;
    setc(0, 0, 0, 0, 0); step(2);
    pulse_a(0); pulse_b(0);
    b_ext[7:0] = 8'h00;
    setc(0, 1, 1, 1, 0); step(2);
    chk("R11 reg A holds driven data", {8'h0, b_o[7:0]}, 16'h0077);
    setc(0, 0, 0, 0, 1); step(2);
    chk("R11 reg B holds same data", {8'h0, a_o[7:0]}, 16'h0077);
    setc(0, 0, 1, 0, 0); step(2);
  endtask

  task automatic t_independent;
    setc(1, 1, 0, 0, 0);
    setc(0, 1, 1, 0, 0); a_ext = 16'hA5_4B; step(2);
    chk("R10 section0 unaffected", {8'h0, b_o[7:0]}, 16'h004B);
    chk("R10 only section1 flags", {14'h0, conflict}, 16'h0002);
    chk("R10 section1 not driving", {a_oe[15:8], b_oe[15:8]}, 16'h0);
    b_ext[15:8] = 8'h6E; pulse_b(1);
    setc(1, 0, 0, 0, 1); step(2);
    chk("R10 section1 own capture", {8'h0, a_o[15:8]}, 16'h006E);
    chk("R10 section0 still live", {8'h0, b_o[7:0]}, 16'h004B);
    setc(0, 0, 1, 0, 0); setc(1, 0, 1, 0, 0); step(2);
  endtask

  initial begin
    t_reset();
    t_realtime();
    t_capture();
    t_both_stored();
    t_conflict();
    t_glitch();
    t_driven_capture();
    t_independent();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule